// File: doc/BRIEF.md
# Repeated-Block Health Monitor

This block sits on a random-data stream, either right after a raw noise source or right after a deterministic generator. It is a pass-through stage with valid/ready handshakes on both sides. Each block it accepts is compared with the block it accepted just before. A block that differs from its predecessor goes to the output unchanged, in the same cycle. A block that equals its predecessor is treated as a health-test failure.

After reset the monitor holds nothing to compare against. The first accepted block therefore only becomes the comparison reference and is dropped. A failure sets a flag that stays set. While the flag is set, the output stays silent and the input keeps accepting and discarding data, so the source upstream can drain. Only reset clears the failure. Reset also empties the reference, so the next block is taken as a new reference.

Top module: `crt_monitor`

## Requirements
- R1: While reset is applied and right after it, `fail_o` is 0 and `out_valid_o` is 0.
- R2: The first block accepted after reset is taken (`in_ready_o` is 1) but not forwarded (`out_valid_o` is 0 while it is presented). It becomes the comparison reference.
- R3: Once a reference is held, an input block that differs from it is forwarded combinationally. `out_valid_o` follows `in_valid_i`, `out_data_o` equals `in_data_i`, and `in_ready_o` follows `out_ready_i`.
- R4: While a differing block is stalled by `out_ready_i` = 0, `in_ready_o` is 0 and the reference does not change. A stall of any length never causes a failure.
- R5: An input block equal to the most recently accepted block is accepted and not forwarded. `fail_o` is 1 from the next cycle on.
- R6: Once `fail_o` is 1, it stays 1 until reset. Meanwhile `out_valid_o` is 0 and `in_ready_o` is 1 for any input.
- R7: Reset clears both the failure and the reference. The block accepted after reset is a new reference, even if it equals a block seen before reset.
- R8: Only the immediately preceding accepted block is compared. A block equal to an older block, but not to the last one, is forwarded.
- R9: The block width is the parameter `W`, with a default of 64 bits, and applies to `in_data_i` and `out_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Input block accepted when high together with valid |
| in_data_i | input | W | Input block |
| out_valid_o | output | 1 | Forwarded block valid |
| out_ready_i | input | 1 | Downstream ready |
| out_data_o | output | W | Forwarded block |
| fail_o | output | 1 | Sticky repetition failure |

## Verification
The hardest situation to reach is a block that is stalled by downstream back-pressure for several cycles and then released. A design that loads the reference on every valid cycle, rather than only on accepted transfers, would report a false repeat against the stalled block. The stimulus drops `out_ready_i` while a fresh block is presented and holds it for several cycles, checking that no failure appears. It then releases the stall and resends the same block. That resend must fail, which proves the reference was loaded exactly once, at the handshake.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY  = 2'd0,
    ST_ARMED  = 2'd1,
    ST_FAILED = 2'd2
  } crt_state_e;
endpackage

// File: rtl/crt_ref_store.sv
module crt_ref_store #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] ref_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ref_o <= '0;
    else if (load_i) ref_o <= data_i;
  end
endmodule

// File: rtl/crt_eq_cmp.sv
module crt_eq_cmp #(
  parameter int W      = 64,
  parameter int LANE_W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  localparam int LANES = (W + LANE_W - 1) / LANE_W;
  localparam int PAD_W = LANES * LANE_W;

  logic [PAD_W-1:0] a_pad, b_pad;
  logic [LANES-1:0] lane_eq;

  assign a_pad = {{(PAD_W-W){1'b0}}, a_i};
  assign b_pad = {{(PAD_W-W){1'b0}}, b_i};

  // split the wide compare into lanes to keep the reduction tree shallow
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (a_pad[g*LANE_W +: LANE_W] == b_pad[g*LANE_W +: LANE_W]);
  end

  assign eq_o = &lane_eq;
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic out_ready_i,
  input  logic eq_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic load_o,
  output logic fail_o
);
  crt_state_e state_q, state_d;
  logic       accept;

  always_comb begin
    in_ready_o  = 1'b1;
    out_valid_o = 1'b0;
    case (state_q)
      ST_ARMED: begin
        if (!eq_i) begin
          in_ready_o  = out_ready_i;
          out_valid_o = in_valid_i;
        end
      end
      default: ;
    endcase
  end

  assign accept = in_valid_i && in_ready_o;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    case (state_q)
      ST_EMPTY: begin
        if (accept) begin
          state_d = ST_ARMED;
          load_o  = 1'b1;
        end
      end
      ST_ARMED: begin
        if (accept) begin
          if (eq_i) state_d = ST_FAILED;
          else      load_o  = 1'b1;
        end
      end
      default: state_d = ST_FAILED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_EMPTY;
    else         state_q <= state_d;
  end

  assign fail_o = (state_q == ST_FAILED);
endmodule

// File: rtl/crt_monitor.sv
module crt_monitor #(
  parameter int W      = 64,
  parameter int LANE_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o,
  output logic         fail_o
);
  logic [W-1:0] ref_q;
  logic         eq;
  logic         load;

  crt_ref_store #(.W(W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (in_data_i),
    .ref_o  (ref_q)
  );

  crt_eq_cmp #(.W(W), .LANE_W(LANE_W)) u_cmp (
    .a_i  (in_data_i),
    .b_i  (ref_q),
    .eq_o (eq)
  );

  crt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .eq_i        (eq),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .load_o      (load),
    .fail_o      (fail_o)
  );

  assign out_data_o = in_data_i;
endmodule

// File: rtl/crt_monitor_chk.sv
module crt_monitor_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic [W-1:0] in_data_i,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] out_data_o,
  input logic         fail_o
);
  p_fail_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!out_valid_o && in_ready_o));

  p_fail_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);

  p_fwd_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (in_valid_i && out_data_o == in_data_i));

  p_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_fail_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(in_valid_i && in_ready_o && !out_valid_o));

  p_stall_no_fail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> !fail_o);
endmodule

bind crt_monitor crt_monitor_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .fail_o      (fail_o)
);

// File: tb/tb_crt_monitor.sv
`timescale 1ns/1ps
module tb_crt_monitor;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic         fail;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  crt_monitor dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data),
    .fail_o      (fail)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected output", out_data, '0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(out_data == e, "R3 forwarded data", out_data, e);
      end
    end
  end

  task automatic send(input logic [W-1:0] d, input bit fwd, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = d;
    if (fwd) exp_q.push_back(d);
    do @(negedge clk); while (!in_ready);
    check(out_valid == fwd, tag, W'(out_valid), W'(fwd));
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_ni = 1'b0;
    #1;
    check(fail == 1'b0 && out_valid == 1'b0, "R1 reset state", {fail, out_valid}, '0);
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    check($bits(out_data) == 64 && $bits(in_data) == 64, "R9 width", W'($bits(out_data)), 64);
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    check(fail == 1'b0 && out_valid == 1'b0, "R1 after reset", {fail, out_valid}, '0);

    send(64'hA5A5_0000_1111_2222, 1'b0, "R2 first block is reference");
    send(64'h0123_4567_89AB_CDEF, 1'b1, "R3 differing block");
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R3 all ones");
    send(64'h0000_0000_0000_0000, 1'b1, "R3 all zeros");
    send(64'h0123_4567_89AB_CDEF, 1'b1, "R8 older block forwarded");
    send(64'h0123_4567_89AB_CDEE, 1'b1, "R3 one bit differs");
    check(fail == 1'b0, "R3 no fail on distinct blocks", W'(fail), '0);

    // back-pressure stall
    @(posedge clk); #1;
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = 64'hDEAD_BEEF_CAFE_F00D;
    exp_q.push_back(in_data);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0 && out_valid == 1'b1 && fail == 1'b0, "R4 stall holds",
            {in_ready, out_valid, fail}, 3'b010);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R4 release", W'(in_ready), 1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(fail == 1'b0, "R4 no false match", W'(fail), '0);

    // repeat of the last accepted block
    send(64'hDEAD_BEEF_CAFE_F00D, 1'b0, "R5 repeat not forwarded");
    check(fail == 1'b1, "R5 fail set", W'(fail), 1);

    send(64'h1111_2222_3333_4444, 1'b0, "R6 blocked after fail");
    send(64'h5555_6666_7777_8888, 1'b0, "R6 blocked after fail");
    out_ready = 1'b0;
    send(64'h9999_AAAA_BBBB_CCCC, 1'b0, "R6 ready high regardless");
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(fail == 1'b1, "R6 fail sticky", W'(fail), 1);

    do_reset();
    @(negedge clk);
    check(fail == 1'b0, "R7 reset clears fail", W'(fail), '0);
    send(64'hDEAD_BEEF_CAFE_F00D, 1'b0, "R7 new reference after reset");
    check(fail == 1'b0, "R7 reference cleared", W'(fail), '0);
    send(64'h7777_0000_7777_0000, 1'b1, "R7 forwarding resumes");
    send(64'h7777_0000_7777_0000, 1'b0, "R5 second repeat");
    check(fail == 1'b1, "R5 fail set again", W'(fail), 1);

    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "R3 scoreboard drained", W'(exp_q.size()), '0);
    finish_run();
  end
endmodule